// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the memory-mapped register side of an I2C master. A host reaches it through a simple word-addressed port. It holds a small command queue that feeds the byte engine and a small receive queue that the byte engine fills. It also holds the SCL and SDA timing counts and a control word. The control word has an enable bit, a speed bit and two queue thresholds. Interrupt sources are collected into one status word, masked by an enable word, and combined onto a single interrupt line. Signalling on the I2C wires belongs to the byte engine and is not part of this block.

The host writes commands to the command address. Each command is a data byte plus a start flag and a stop flag. The byte engine pops commands while they are offered. Bytes that the engine receives are pushed into the receive queue. The host pops them by reading the receive-data address.

A three-state run controller follows the enable bit. From OFF it moves to RUN once the enable bit is set. From RUN it moves to FLUSH once the enable bit is cleared. FLUSH always lasts exactly one cycle. It then goes back to RUN if the enable bit has been set again, and to OFF otherwise. The engine is released only in RUN. In OFF and FLUSH both queues are held empty.

Top module: `i2cm_csr`

## Requirements
- R1: After reset, the control word, the interrupt enable word and the three timing registers read 0. Both queue levels read 0, `irq` and `eng_run` are low, and the interrupt status reads 0x01, because the empty command queue is at or below threshold 0.
- R2: The word addresses are: command 0x00, receive data 0x04, control 0x08, interrupt enable 0x0C, interrupt status 0x10, core status 0x14, command level 0x18, receive level 0x1C, SCL low 0x20, SCL high 0x24, SDA hold 0x28. Control bits [5:0] read back as written. The three timing registers read back their low 16 bits and drive `scl_low_cnt`, `scl_high_cnt` and `sda_hold_cnt`. Control bit 1 drives `fast_mode`.
- R3: In RUN, a write to 0x00 queues bits [9:0]: bit 9 is start, bit 8 is stop and bits [7:0] are data. Entries leave in write order on `cmd_data` while `cmd_valid` is high, one for each `cmd_pop`. The level at 0x18 never exceeds the depth of 4, and a write to a full queue is dropped.
- R4: In RUN, a cycle with `rx_push` high queues `rx_byte`. A read of 0x04 returns the oldest byte in bits [7:0] and removes it. A read of an empty queue returns 0. The level is at 0x1C.
- R5: A push into a full receive queue drops the byte and sets status bit 4, the receive-overflow bit. That bit stays set after the queue is drained.
- R6: Status bit 0 (TX ready) is 1 exactly while the command level is less than or equal to control bits [3:2].
- R7: Status bit 1 (RX ready) is 1 exactly while the receive level is greater than control bits [5:4].
- R8: A pulse on `ev_nack` sets status bit 2 and a pulse on `ev_arb` sets status bit 3; both bits stay set. Writing 1 to bit 2, 3 or 4 of 0x10 clears that bit, and writing 0 leaves it unchanged. Writes to 0x10 do not change bits 0 and 1. A set and a clear in the same cycle leave the bit set.
- R9: `irq` is high exactly while some status bit and the interrupt enable bit at the same position (0x0C, bits [4:0]) are both 1.
- R10: Control bit 0 is the enable. After it is cleared, `eng_run` falls and both queues become empty, while the control, enable and timing registers keep their values. While disabled, command writes are dropped. The run controller moves from RUN to FLUSH one cycle after the enable bit clears.
- R11: Bit 0 of the core status word at 0x14 follows the `eng_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel | input | 1 | Register access in this cycle |
| csr_wr | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 6 | Byte address of the word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the addressed word |
| cmd_valid | output | 1 | Command queue not empty and running |
| cmd_data | output | 10 | Oldest command: start, stop, byte |
| cmd_pop | input | 1 | Engine takes the offered command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_nack | input | 1 | Pulse: no acknowledge seen |
| ev_arb | input | 1 | Pulse: arbitration lost |
| eng_busy | input | 1 | Engine is busy on the bus |
| eng_run | output | 1 | Engine released from reset |
| fast_mode | output | 1 | Fast bus speed selected |
| scl_low_cnt | output | 16 | SCL low period count |
| scl_high_cnt | output | 16 | SCL high period count |
| sda_hold_cnt | output | 16 | SDA hold count |
| irq | output | 1 | Interrupt request |

## Verification
The overflow bit is the hardest state to reach. It needs the engine to run, the receive queue to be full with no host read in between, and then a fifth push. The stimulus first raises the receive threshold to 2, so that RX ready is seen to rise only at the third byte. It then pushes two more bytes, reads back the four bytes that were kept, and checks that the sticky bit survives the drain. Flushing on disable is reached with both queues partly filled, so that one control write must empty both.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } run_state_e;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned CMD_W  = 10;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NSRC   = 5;

    localparam int unsigned SRC_TXRDY = 0;
    localparam int unsigned SRC_RXRDY = 1;
    localparam int unsigned SRC_NACK  = 2;
    localparam int unsigned SRC_ARB   = 3;
    localparam int unsigned SRC_OVF   = 4;

    localparam logic [3:0] WA_CMD  = 4'd0;
    localparam logic [3:0] WA_RXD  = 4'd1;
    localparam logic [3:0] WA_CTRL = 4'd2;
    localparam logic [3:0] WA_IEN  = 4'd3;
    localparam logic [3:0] WA_ISR  = 4'd4;
    localparam logic [3:0] WA_STAT = 4'd5;
    localparam logic [3:0] WA_CLVL = 4'd6;
    localparam logic [3:0] WA_RLVL = 4'd7;
    localparam logic [3:0] WA_SLO  = 4'd8;
    localparam logic [3:0] WA_SHI  = 4'd9;
    localparam logic [3:0] WA_HOLD = 4'd10;

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           full,
    output logic                           empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == LVL_FULL);
    assign empty   = (level == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2cm_runctl.sv
module i2cm_runctl
    import i2cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic run,
    output logic flush
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_req)  state_d = ST_RUN;
            ST_RUN:   if (!en_req) state_d = ST_FLUSH;
            ST_FLUSH: state_d = en_req ? ST_RUN : ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        run   = 1'b0;
        flush = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                run   = 1'b1;
                flush = 1'b0;
            end
            ST_OFF, ST_FLUSH: begin
                run   = 1'b0;
                flush = 1'b1;
            end
            default: begin
                run   = 1'b0;
                flush = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/i2cm_irqctl.sv
module i2cm_irqctl
    import i2cm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_rdy,
    input  logic            rx_rdy,
    input  logic            set_nack,
    input  logic            set_arb,
    input  logic            set_ovf,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] ien,
    output logic [NSRC-1:0] status,
    output logic            irq
);
    localparam int unsigned NSTICKY = 3;

    logic [NSTICKY-1:0] sticky_q;
    logic [NSTICKY-1:0] sticky_set;
    logic [NSTICKY-1:0] sticky_clr;

    assign sticky_set = {set_ovf, set_arb, set_nack};
    assign sticky_clr = clr_we ? clr_mask[SRC_OVF:SRC_NACK] : '0;

    for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky_q[g] <= 1'b0;
            end else if (sticky_set[g]) begin
                sticky_q[g] <= 1'b1;
            end else if (sticky_clr[g]) begin
                sticky_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        status = '0;
        status[SRC_TXRDY] = tx_rdy;
        status[SRC_RXRDY] = rx_rdy;
        status[SRC_OVF:SRC_NACK] = sticky_q;
    end

    assign irq = |(status & ien);

endmodule

// File: rtl/i2cm_csr.sv
module i2cm_csr
    import i2cm_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned TIME_W     = 16,
    parameter int unsigned THR_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_sel,
    input  logic                 csr_wr,
    input  logic [5:0]           csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    output logic                 cmd_valid,
    output logic [9:0]           cmd_data,
    input  logic                 cmd_pop,
    input  logic                 rx_push,
    input  logic [7:0]           rx_byte,
    input  logic                 ev_nack,
    input  logic                 ev_arb,
    input  logic                 eng_busy,
    output logic                 eng_run,
    output logic                 fast_mode,
    output logic [TIME_W-1:0]    scl_low_cnt,
    output logic [TIME_W-1:0]    scl_high_cnt,
    output logic [TIME_W-1:0]    sda_hold_cnt,
    output logic                 irq
);
    localparam int unsigned LVL_W   = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned CTL_W   = 2 + 2 * THR_W;
    localparam int unsigned THC_LSB = 2;
    localparam int unsigned THR_LSB = 2 + THR_W;

    logic [3:0]        word;
    logic              wr_hit, rd_hit;
    logic [CTL_W-1:0]  ctl_q;
    logic [NSRC-1:0]   ien_q;
    logic [TIME_W-1:0] slo_q, shi_q, hold_q;
    logic              ctl_en;
    logic [THR_W-1:0]  thr_cmd, thr_rx;
    logic              fifo_clr;

    logic              cmd_push, cmd_full, cmd_empty;
    logic [LVL_W-1:0]  cmd_lvl;
    logic              rx_pop, rx_full, rx_empty, rx_take;
    logic [7:0]        rx_head;
    logic [LVL_W-1:0]  rx_lvl;

    logic              tx_rdy, rx_rdy, ovf_set;
    logic [NSRC-1:0]   isr_val;

    assign word   = csr_addr[ADDR_W-1:2];
    assign wr_hit = csr_sel && csr_wr;
    assign rd_hit = csr_sel && !csr_wr;

    assign ctl_en    = ctl_q[0];
    assign fast_mode = ctl_q[1];
    assign thr_cmd   = ctl_q[THC_LSB +: THR_W];
    assign thr_rx    = ctl_q[THR_LSB +: THR_W];

    assign scl_low_cnt  = slo_q;
    assign scl_high_cnt = shi_q;
    assign sda_hold_cnt = hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            ien_q  <= '0;
            slo_q  <= '0;
            shi_q  <= '0;
            hold_q <= '0;
        end else if (wr_hit) begin
            case (word)
                WA_CTRL: ctl_q  <= csr_wdata[CTL_W-1:0];
                WA_IEN:  ien_q  <= csr_wdata[NSRC-1:0];
                WA_SLO:  slo_q  <= csr_wdata[TIME_W-1:0];
                WA_SHI:  shi_q  <= csr_wdata[TIME_W-1:0];
                WA_HOLD: hold_q <= csr_wdata[TIME_W-1:0];
                default: ;
            endcase
        end
    end

    i2cm_runctl u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_req (ctl_en),
        .run    (eng_run),
        .flush  (fifo_clr)
    );

    assign cmd_push = wr_hit && (word == WA_CMD) && eng_run;

    i2cm_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmdq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (cmd_push),
        .din   (csr_wdata[CMD_W-1:0]),
        .pop   (cmd_pop && eng_run),
        .dout  (cmd_data),
        .level (cmd_lvl),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    assign cmd_valid = !cmd_empty && eng_run;

    assign rx_take = rx_push && eng_run;
    assign rx_pop  = rd_hit && (word == WA_RXD);

    i2cm_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (rx_take),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_rdy  = (32'(cmd_lvl) <= 32'(thr_cmd));
    assign rx_rdy  = (32'(rx_lvl) > 32'(thr_rx));
    assign ovf_set = rx_take && rx_full;

    i2cm_irqctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_rdy   (tx_rdy),
        .rx_rdy   (rx_rdy),
        .set_nack (ev_nack),
        .set_arb  (ev_arb),
        .set_ovf  (ovf_set),
        .clr_we   (wr_hit && (word == WA_ISR)),
        .clr_mask (csr_wdata[NSRC-1:0]),
        .ien      (ien_q),
        .status   (isr_val),
        .irq      (irq)
    );

    always_comb begin
        csr_rdata = '0;
        case (word)
            WA_RXD:  csr_rdata = rx_empty ? '0 : 32'(rx_head);
            WA_CTRL: csr_rdata = 32'(ctl_q);
            WA_IEN:  csr_rdata = 32'(ien_q);
            WA_ISR:  csr_rdata = 32'(isr_val);
            WA_STAT: csr_rdata = 32'(eng_busy);
            WA_CLVL: csr_rdata = 32'(cmd_lvl);
            WA_RLVL: csr_rdata = 32'(rx_lvl);
            WA_SLO:  csr_rdata = 32'(slo_q);
            WA_SHI:  csr_rdata = 32'(shi_q);
            WA_HOLD: csr_rdata = 32'(hold_q);
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2cm_csr_chk.sv
module i2cm_csr_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ctl_en,
    input logic [LVL_W-1:0] cmd_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic             rx_push,
    input logic             rx_full,
    input logic [4:0]       isr,
    input logic [4:0]       ien,
    input logic             ev_nack,
    input logic             ev_arb,
    input logic             irq
);
    p_lvl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cmd_lvl) <= DEPTH) && (32'(rx_lvl) <= DEPTH));

    p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && run && rx_full) |=> isr[4]);

    p_nack_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> isr[2]);

    p_arb_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |=> isr[3]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 5'd0));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cmd_lvl == '0) && (rx_lvl == '0));

    p_leave_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl_en) |=> !run);

endmodule

bind i2cm_csr i2cm_csr_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (eng_run),
    .ctl_en  (ctl_en),
    .cmd_lvl (cmd_lvl),
    .rx_lvl  (rx_lvl),
    .rx_push (rx_push),
    .rx_full (rx_full),
    .isr     (isr_val),
    .ien     (ien_q),
    .ev_nack (ev_nack),
    .ev_arb  (ev_arb),
    .irq     (irq)
);

// File: tb/sim_i2cm_csr.sv
`timescale 1ns/1ps
module sim_i2cm_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_sel = 1'b0, csr_wr = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        cmd_valid;
    logic [9:0]  cmd_data;
    logic        cmd_pop = 1'b0, rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ev_nack = 1'b0, ev_arb = 1'b0, eng_busy = 1'b0;
    logic        eng_run, fast_mode, irq;
    logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2cm_csr u0 (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .ev_nack(ev_nack), .ev_arb(ev_arb),
        .eng_busy(eng_busy), .eng_run(eng_run), .fast_mode(fast_mode),
        .scl_low_cnt(scl_low_cnt), .scl_high_cnt(scl_high_cnt),
        .sda_hold_cnt(sda_hold_cnt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
        @(negedge clk);
        csr_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic eng_pop_chk(input string req, input logic [9:0] exp);
        @(negedge clk);
        check(req, {22'd0, cmd_data}, {22'd0, exp});
        cmd_pop = 1'b1;
        @(negedge clk);
        cmd_pop = 1'b0;
    endtask

    task automatic pulse_nack();
        @(negedge clk); ev_nack = 1'b1;
        @(negedge clk); ev_nack = 1'b0;
    endtask

    task automatic pulse_arb();
        @(negedge clk); ev_arb = 1'b1;
        @(negedge clk); ev_arb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic t_reset();
        check("R1 eng_run", {31'd0, eng_run}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd_chk("R1 ctrl", 6'h08, 0);
        rd_chk("R1 ien", 6'h0C, 0);
        rd_chk("R1 isr", 6'h10, 32'h01);
        rd_chk("R1 clvl", 6'h18, 0);
        rd_chk("R1 rlvl", 6'h1C, 0);
        rd_chk("R1 slo", 6'h20, 0);
    endtask

    task automatic t_regs();
        wr(6'h08, 32'hFFFF_FFFE);
        rd_chk("R2 ctrl mask", 6'h08, 32'h3E);
        check("R2 fast_mode", {31'd0, fast_mode}, 1);
        wr(6'h20, 32'hABCD_1234);
        wr(6'h24, 32'h5678);
        wr(6'h28, 32'h9ABC);
        rd_chk("R2 slo", 6'h20, 32'h1234);
        rd_chk("R2 shi", 6'h24, 32'h5678);
        rd_chk("R2 hold", 6'h28, 32'h9ABC);
        check("R2 slo out", {16'd0, scl_low_cnt}, 32'h1234);
        check("R2 shi out", {16'd0, scl_high_cnt}, 32'h5678);
        check("R2 hold out", {16'd0, sda_hold_cnt}, 32'h9ABC);
        wr(6'h08, 32'h0);
        check("R2 fast off", {31'd0, fast_mode}, 0);
    endtask

    task automatic t_disabled_drop();
        idle(3);
        wr(6'h00, 32'h2A5);
        rd_chk("R10 cmd dropped while off", 6'h18, 0);
        check("R10 no cmd_valid", {31'd0, cmd_valid}, 0);
    endtask

    task automatic t_cmd_order();
        wr(6'h08, 32'h01);
        idle(2);
        check("R10 run after enable", {31'd0, eng_run}, 1);
        wr(6'h00, 32'h2A0);
        wr(6'h00, 32'h055);
        wr(6'h00, 32'h03C);
        wr(6'h00, 32'h111);
        rd_chk("R3 level full", 6'h18, 4);
        wr(6'h00, 32'h0FF);
        rd_chk("R3 full write dropped", 6'h18, 4);
        check("R3 cmd_valid", {31'd0, cmd_valid}, 1);
        eng_pop_chk("R3 first", 10'h2A0);
        eng_pop_chk("R3 second", 10'h055);
        eng_pop_chk("R3 third", 10'h03C);
        eng_pop_chk("R3 fourth", 10'h111);
        check("R3 drained", {31'd0, cmd_valid}, 0);
    endtask

    task automatic t_tx_thr();
        wr(6'h08, 32'h05);
        rd_chk("R6 level0 ready", 6'h10, 32'h01);
        wr(6'h00, 32'h001);
        wr(6'h00, 32'h002);
        rd_chk("R6 level2 not ready", 6'h10, 32'h00);
        eng_pop_chk("R6 pop", 10'h001);
        rd_chk("R6 level1 ready", 6'h10, 32'h01);
        eng_pop_chk("R6 pop2", 10'h002);
    endtask

    task automatic t_rx_ovf();
        wr(6'h08, 32'h21);
        eng_push(8'h11);
        eng_push(8'h22);
        rd_chk("R7 level2 not ready", 6'h10, 32'h01);
        eng_push(8'h33);
        rd_chk("R7 level3 ready", 6'h10, 32'h03);
        eng_push(8'h44);
        eng_push(8'h55);
        rd_chk("R5 ovf set", 6'h10, 32'h13);
        rd_chk("R5 level kept", 6'h1C, 4);
        rd_chk("R4 byte1", 6'h04, 32'h11);
        rd_chk("R4 byte2", 6'h04, 32'h22);
        rd_chk("R4 byte3", 6'h04, 32'h33);
        rd_chk("R5 byte4 kept, byte5 dropped", 6'h04, 32'h44);
        rd_chk("R4 empty read", 6'h04, 0);
        rd_chk("R4 level0", 6'h1C, 0);
        rd_chk("R5 ovf sticky", 6'h10, 32'h11);
        wr(6'h10, 32'h10);
        rd_chk("R8 ovf cleared", 6'h10, 32'h01);
    endtask

    task automatic t_sticky();
        wr(6'h08, 32'h01);
        pulse_nack();
        rd_chk("R8 nack set", 6'h10, 32'h05);
        wr(6'h10, 32'h0);
        rd_chk("R8 write 0 keeps", 6'h10, 32'h05);
        wr(6'h10, 32'h04);
        rd_chk("R8 nack cleared", 6'h10, 32'h01);
        pulse_arb();
        rd_chk("R8 arb set", 6'h10, 32'h09);
        wr(6'h10, 32'h0B);
        rd_chk("R8 arb cleared, tx live", 6'h10, 32'h01);
    endtask

    task automatic t_irq();
        wr(6'h0C, 32'h04);
        check("R9 masked tx", {31'd0, irq}, 0);
        pulse_nack();
        check("R9 nack irq", {31'd0, irq}, 1);
        wr(6'h0C, 32'h00);
        check("R9 disabled", {31'd0, irq}, 0);
        wr(6'h10, 32'h04);
        wr(6'h0C, 32'h01);
        check("R9 tx irq", {31'd0, irq}, 1);
        wr(6'h0C, 32'h00);
    endtask

    task automatic t_flush();
        wr(6'h08, 32'h0D);
        eng_push(8'h77);
        eng_push(8'h88);
        wr(6'h00, 32'h001);
        wr(6'h00, 32'h002);
        rd_chk("R10 pre rlvl", 6'h1C, 2);
        wr(6'h08, 32'h0C);
        idle(3);
        check("R10 run low", {31'd0, eng_run}, 0);
        rd_chk("R10 clvl flushed", 6'h18, 0);
        rd_chk("R10 rlvl flushed", 6'h1C, 0);
        rd_chk("R10 ctrl kept", 6'h08, 32'h0C);
        rd_chk("R10 timing kept", 6'h24, 32'h5678);
        wr(6'h08, 32'h0D);
        idle(2);
        check("R10 rerun", {31'd0, eng_run}, 1);
        check("R10 still empty", {31'd0, cmd_valid}, 0);
    endtask

    task automatic t_busy();
        eng_busy = 1'b1;
        rd_chk("R11 busy", 6'h14, 1);
        eng_busy = 1'b0;
        rd_chk("R11 idle", 6'h14, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled_drop();
        t_cmd_order();
        t_tx_thr();
        t_rx_ovf();
        t_sticky();
        t_irq();
        t_flush();
        t_busy();
        done = 1'b1;
        report();
    end
endmodule